// File: doc/BRIEF.md
# Flag-Setting Data-Processing ALU

This block is the integer data-processing unit of a small RISC core. Each cycle it takes a 4-bit operation code, a first operand, and a second operand that has already passed through the barrel shifter. It also takes the carry bit the shifter produced and a set-flags request. From these it forms a result and a destination write-enable, and it works out the next negative, zero, carry and overflow condition flags. The shifter, the condition-code test and the register file are outside this block.

The condition flags sit in a register inside the block, which loads the computed next value when the flag enable is high. The stored carry feeds the carry-using operations (add-with-carry and the two subtract-with-carry forms). The stored flags also supply every flag that an operation leaves unchanged. Subtract forms report carry as "no borrow". Logical forms copy the shifter carry into C and do not touch V.

Top module: `alu_dp_core`

## Requirements
- R1: Logical codes give: 0 = a AND b, 1 = a XOR b, 12 = a OR b, 13 = b, 14 = a AND NOT b, 15 = NOT b. The probe codes 8 and 9 give a AND b and a XOR b on `result`.
- R2: Arithmetic codes give: 2 = a - b, 3 = b - a, 4 = a + b, 5 = a + b + C, 6 = a - b - (1 - C), 7 = b - a - (1 - C). Probe codes 10 = a - b and 11 = a + b. C is the stored carry (`flags_q[1]`), and every result is taken modulo 2^WIDTH.
- R3: `wr_en` is 0 for codes 8 to 11 and 1 for all other codes.
- R4: Codes 8 to 11 update the flags even when `set_flags` is 0.
- R5: For codes outside 8 to 11 with `set_flags` 0, `flags_next` equals `flags_q`.
- R6: When flags update, N (`flags_next[3]`) is the result MSB and Z (`flags_next[2]`) is 1 exactly when the result is zero.
- R7: When flags update on an addition (4, 5, 11), C (`flags_next[1]`) is the carry out of the MSB. On a subtraction (2, 3, 6, 7, 10), C is 1 when minuend >= subtrahend + borrow-in, treated as unsigned.
- R8: When flags update on an addition, V (`flags_next[0]`) is 1 when both operands share a sign that differs from the result's sign. On a subtraction, V is 1 when minuend and subtrahend differ in sign and the result's sign differs from the minuend's.
- R9: When flags update on a logical code (0, 1, 8, 9, 12 to 15), C takes `shift_carry` and V keeps its stored value.
- R10: `flags_q` resets to 0. It loads `flags_next` on a clock edge with `flag_en` 1 and holds when `flag_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_en | input | 1 | Load enable for the flag register |
| op | input | 4 | Operation code |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Shifted second operand |
| shift_carry | input | 1 | Carry out of the shifter |
| set_flags | input | 1 | Request a flag update |
| result | output | WIDTH | Operation result |
| wr_en | output | 1 | Destination write-enable |
| flags_next | output | 4 | Next flags {N,Z,C,V} |
| flags_q | output | 4 | Stored flags {N,Z,C,V} |

## Verification
The flag register is the only state in the block. If it is wrong, the fault shows up in one of two ways. `flags_q` shows the bad value one clock after the faulty load. On the same cycle, every carry-using result and every preserved flag bit in `flags_next` also goes wrong. The bench sweeps a 4-bit configuration exhaustively: every code, every operand pair, both stored carries, both shifter carries and both set-flags values. Before each vector it loads the carry through a flag-setting move, so a bad carry path shows up within two cycles.

// File: rtl/alu_dp_pkg.sv
package alu_dp_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
        OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
        OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
        OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_LOGIC = 2'd0,
        CLS_ADD   = 2'd1,
        CLS_SUB   = 2'd2
    } op_class_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    function automatic op_class_e op_class(alu_op_e op);
        case (op)
            OP_ADD, OP_ADC, OP_CMN:                 return CLS_ADD;
            OP_SUB, OP_RSB, OP_SBC, OP_RSC, OP_CMP: return CLS_SUB;
            default:                                return CLS_LOGIC;
        endcase
    endfunction

    // Probe operations produce flags only, never a register write.
    function automatic logic op_is_probe(alu_op_e op);
        return (op == OP_TST) || (op == OP_TEQ) || (op == OP_CMP) || (op == OP_CMN);
    endfunction

endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_dp_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] res
);
    always_comb begin
        case (op)
            OP_AND, OP_TST: res = a & b;
            OP_EOR, OP_TEQ: res = a ^ b;
            OP_ORR:         res = a | b;
            OP_MOV:         res = b;
            OP_BIC:         res = a & ~b;
            OP_MVN:         res = ~b;
            default:        res = '0;
        endcase
    end
endmodule

// File: rtl/alu_addsub_unit.sv
module alu_addsub_unit
    import alu_dp_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             c_in,
    output logic [WIDTH-1:0] sum,
    output logic             c_out,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic             reverse;
    logic             subtract;
    logic             use_c;
    logic [WIDTH-1:0] x;
    logic [WIDTH-1:0] y;
    logic             cin;
    logic [WIDTH:0]   full;

    always_comb begin
        reverse  = (op == OP_RSB) || (op == OP_RSC);
        subtract = (op_class(op) == CLS_SUB);
        use_c    = (op == OP_ADC) || (op == OP_SBC) || (op == OP_RSC);
        x        = reverse ? b : a;
        y        = reverse ? a : b;
        if (subtract) y = ~y;
        // Subtraction: carry-in 1 means no borrow; with carry forms it is C.
        if (use_c)         cin = c_in;
        else if (subtract) cin = 1'b1;
        else               cin = 1'b0;
        full  = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
        sum   = full[WIDTH-1:0];
        c_out = full[WIDTH];
        // Same-signed adder inputs and a sign change in the sum mean overflow.
        ovf   = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
    end
endmodule

// File: rtl/alu_dp_core.sv
module alu_dp_core
    import alu_dp_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flag_en,
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             shift_carry,
    input  logic             set_flags,
    output logic [WIDTH-1:0] result,
    output logic             wr_en,
    output logic [3:0]       flags_next,
    output logic [3:0]       flags_q
);
    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] result;
        logic             wr_en;
        nzcv_t            flags;
    } core_t;

    alu_op_e          op_e;
    nzcv_t            flg_q;
    core_t            core_d;
    logic [WIDTH-1:0] logic_res;
    logic [WIDTH-1:0] arith_res;
    logic             arith_c;
    logic             arith_v;

    assign op_e = alu_op_e'(op);

    alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .op  (op_e),
        .a   (opnd_a),
        .b   (opnd_b),
        .res (logic_res)
    );

    alu_addsub_unit #(.WIDTH(WIDTH)) u_addsub (
        .op    (op_e),
        .a     (opnd_a),
        .b     (opnd_b),
        .c_in  (flg_q.c),
        .sum   (arith_res),
        .c_out (arith_c),
        .ovf   (arith_v)
    );

    always_comb begin
        logic update;
        core_d        = '0;
        core_d.flags  = flg_q;
        core_d.wr_en  = !op_is_probe(op_e);
        core_d.result = (op_class(op_e) == CLS_LOGIC) ? logic_res : arith_res;
        update        = set_flags || op_is_probe(op_e);
        if (update) begin
            core_d.flags.n = core_d.result[MSB];
            core_d.flags.z = (core_d.result == '0);
            if (op_class(op_e) == CLS_LOGIC) begin
                core_d.flags.c = shift_carry;
            end else begin
                core_d.flags.c = arith_c;
                core_d.flags.v = arith_v;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flg_q <= '0;
        else if (flag_en) flg_q <= core_d.flags;
    end

    assign result     = core_d.result;
    assign wr_en      = core_d.wr_en;
    assign flags_next = core_d.flags;
    assign flags_q    = flg_q;
endmodule

// File: rtl/alu_dp_checker.sv
module alu_dp_checker #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flag_en,
    input logic [3:0]       op,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic             shift_carry,
    input logic             set_flags,
    input logic [WIDTH-1:0] result,
    input logic             wr_en,
    input logic [3:0]       flags_next,
    input logic [3:0]       flags_q
);
    logic probe;
    logic logical;
    assign probe   = (op >= 4'd8) && (op <= 4'd11);
    assign logical = (op <= 4'd1) || (op == 4'd8) || (op == 4'd9) || (op >= 4'd12);

    a_r3_probe_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        probe |-> !wr_en);

    a_r3_other_write: assert property (@(posedge clk) disable iff (!rst_n)
        !probe |-> wr_en);

    a_r4_probe_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        probe |-> (flags_next[2] == (result == '0)));

    a_r5_hold_without_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!probe && !set_flags) |-> (flags_next == flags_q));

    a_r6_negative_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (probe || set_flags) |-> (flags_next[3] == result[WIDTH-1]));

    a_r9_logic_carry_v: assert property (@(posedge clk) disable iff (!rst_n)
        (logical && (probe || set_flags)) |->
            (flags_next[1] == shift_carry && flags_next[0] == flags_q[0]));

    a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
        flag_en |=> (flags_q == $past(flags_next)));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_en |=> $stable(flags_q));
endmodule

bind alu_dp_core alu_dp_checker #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flag_en     (flag_en),
    .op          (op),
    .opnd_a      (opnd_a),
    .opnd_b      (opnd_b),
    .shift_carry (shift_carry),
    .set_flags   (set_flags),
    .result      (result),
    .wr_en       (wr_en),
    .flags_next  (flags_next),
    .flags_q     (flags_q)
);

// File: tb/tb_alu_dp_core.sv
module tb_alu_dp_core;
    localparam int W    = 4;
    localparam int MOD  = 1 << W;
    localparam int MASK = MOD - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         flag_en = 1'b0;
    logic [3:0]   op = '0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic         shift_carry = 1'b0;
    logic         set_flags = 1'b0;
    logic [W-1:0] result;
    logic         wr_en;
    logic [3:0]   flags_next;
    logic [3:0]   flags_q;

    int vectors = 0;
    int fails   = 0;
    logic [3:0] model_q = 4'h0;

    always #10 clk = ~clk;

    alu_dp_core #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .flag_en(flag_en), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .shift_carry(shift_carry),
        .set_flags(set_flags), .result(result), .wr_en(wr_en),
        .flags_next(flags_next), .flags_q(flags_q)
    );

    task automatic check(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s op=%0d a=%0d b=%0d sc=%0d s=%0d actual=%0h expected=%0h",
                     req, op, opnd_a, opnd_b, shift_carry, set_flags, act, exp);
        end
    endtask

    // Reference: result, write flag and next flags, from the requirement text.
    task automatic model(input int o, input int a, input int b, input int sc,
                         input int s, input logic [3:0] cur,
                         output int r, output int wr, output logic [3:0] nf);
        int cflag, m, t, bor, d, full;
        logic upd, is_logic;
        cflag = cur[1];
        nf = cur;
        wr = (o >= 8 && o <= 11) ? 0 : 1;             // R3
        upd = (s != 0) || (o >= 8 && o <= 11);        // R4, R5
        is_logic = 1'b0;
        r = 0;
        case (o)
            0, 8:  begin r = a & b;            is_logic = 1'b1; end
            1, 9:  begin r = a ^ b;            is_logic = 1'b1; end
            12:    begin r = a | b;            is_logic = 1'b1; end
            13:    begin r = b;                is_logic = 1'b1; end
            14:    begin r = a & ~b & MASK;    is_logic = 1'b1; end
            15:    begin r = ~b & MASK;        is_logic = 1'b1; end
            4, 5, 11: begin
                full = a + b + ((o == 5) ? cflag : 0);
                r = full & MASK;
                if (upd) begin
                    nf[1] = (full >= MOD);                                  // R7
                    nf[0] = (((a >> (W-1)) & 1) == ((b >> (W-1)) & 1)) &&
                            (((r >> (W-1)) & 1) != ((a >> (W-1)) & 1));     // R8
                end
            end
            default: begin
                m = (o == 3 || o == 7) ? b : a;
                t = (o == 3 || o == 7) ? a : b;
                bor = (o == 6 || o == 7) ? (1 - cflag) : 0;
                d = m - t - bor;
                r = d & MASK;
                if (upd) begin
                    nf[1] = (d >= 0);                                       // R7
                    nf[0] = (((m >> (W-1)) & 1) != ((t >> (W-1)) & 1)) &&
                            (((r >> (W-1)) & 1) != ((m >> (W-1)) & 1));     // R8
                end
            end
        endcase
        if (upd) begin
            nf[3] = (r >> (W-1)) & 1;                 // R6
            nf[2] = (r == 0);
            if (is_logic) nf[1] = sc[0];              // R9
        end
    endtask

    task automatic apply(int o, int a, int b, int sc, int s, logic en);
        int er, ew;
        logic [3:0] enf;
        @(negedge clk);
        op = o[3:0]; opnd_a = a[W-1:0]; opnd_b = b[W-1:0];
        shift_carry = sc[0]; set_flags = s[0]; flag_en = en;
        model(o, a, b, sc, s, model_q, er, ew, enf);
        #1;
        if (o >= 2 && o <= 7 || o == 10 || o == 11) check("R2 result", int'(result), er);
        else                                        check("R1 result", int'(result), er);
        check("R3 wr_en", int'(wr_en), ew);
        check("R6/R7/R8/R9/R4/R5 flags_next", int'(flags_next), int'(enf));
        if (en) model_q = enf;
        @(posedge clk);
        #1;
        check("R10 flags_q", int'(flags_q), int'(model_q));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset flags_q", int'(flags_q), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 2; c++)
            for (int o = 0; o < 16; o++)
                for (int a = 0; a < MOD; a++)
                    for (int b = 0; b < MOD; b++)
                        for (int sc = 0; sc < 2; sc++)
                            for (int s = 0; s < 2; s++) begin
                                // preload stored C (and N/Z) with a flag-setting move
                                apply(13, 0, (a + b) & MASK, c, 1, 1'b1);
                                apply(o, a, b, sc, s, 1'b1);
                            end
        // R10: flags hold while the enable is low
        apply(10, 0, 1, 0, 1, 1'b1);
        for (int o = 0; o < 16; o++)
            apply(o, 7, 8, 1, 1, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule